// File: doc/BRIEF.md
# Write Status Polling Responder

This block sits in the read path of a word-wide flash array. While the internal program or erase timer is running, a host read does not return the array word unchanged. Some bit positions are replaced with status, so software can tell when the operation is finished by reading the data bus alone. When the operation completes, reads return the array word as stored.

Status is placed in the same bit positions of every byte lane. The top bit of each lane is a polarity bit. During a program it is the complement of that lane's top bit in the word last written. During an erase it reads 0. The next bit down of each lane is a toggle bit. Its value flips after each completed read strobe while the operation is busy. Every other bit returns the array word at the read address.

The command decoder supplies these inputs: the busy flag, the operation type, and the top bit of each lane of the last written word. The array supplies the array word. The block drives its data only while chip select and output enable are both low. The pad buffer uses `driveEn` to switch its output between driving and high impedance.

Top module: `wsp_top`

## Requirements
- R1: `driveEn` is 1 only when `chipSelN` and `outEnN` are both 0. When `driveEn` is 0, `dataOut` is all zeros. After reset, `driveEn` and `dataOut` are both 0.
- R2: With `busy` low and a read active, `dataOut` equals `arrayData` in every bit.
- R3: With `busy` high and `opErase` 0 (program), bit 15 of `dataOut` is the inverse of `lastMsb[1]`, and bit 7 is the inverse of `lastMsb[0]`.
- R4: With `busy` high and `opErase` 1 (erase), bits 15 and 7 of `dataOut` read 0.
- R5: With `busy` high, bits 14 and 6 of `dataOut` both carry the toggle state. The toggle state inverts once per completed read, which is the cycle after the read-active condition ends. It does not change while a read is held across several clocks.
- R6: With `busy` high, all bits of `dataOut` other than 15, 14, 7 and 6 equal `arrayData`.
- R7: The toggle state is 0 after reset. It is cleared to 0 on the clock where `busy` rises, so the first read of every operation shows 0 on bits 14 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chipSelN | input | 1 | Active-low chip select |
| outEnN | input | 1 | Active-low output enable |
| busy | input | 1 | Internal program/erase operation in progress |
| opErase | input | 1 | 1 = running operation is an erase, 0 = program |
| lastMsb | input | 2 | Top bit of each byte lane of the word last written (bit g = lane g) |
| arrayData | input | 16 | Array word at the current read address |
| dataOut | output | 16 | Read data toward the pad buffer |
| driveEn | output | 1 | Pad buffer enable; 0 means the bus is high impedance |

## Verification
Program-busy reads sweep last-written words whose two lane MSBs take all four combinations, over several array patterns. This separates a correct per-lane complement from swapped lanes or an uninverted copy. Erase-busy reads use an all-ones array, so polarity bits reading 0 cannot be confused with array data. Reads of varying hold length, with odd and even counts per operation, distinguish per-strobe from per-clock toggling and show that each new operation clears the toggle. Chip select and output enable are driven separately to confirm that either one alone keeps the bus released.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
  typedef struct packed {
    logic toggleClr;  // new operation started
    logic toggleAdv;  // a busy read strobe just completed
  } wspStrobe_t;
endpackage

// File: rtl/wsp_ctrl.sv
module wsp_ctrl
  import wsp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipSelN,
  input  logic       outEnN,
  input  logic       busy,
  output logic       rdAct,
  output wspStrobe_t strb
);
  logic rdActQ;
  logic busyQ;

  assign rdAct = ~chipSelN & ~outEnN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdActQ <= 1'b0;
      busyQ  <= 1'b0;
    end else begin
      rdActQ <= rdAct;
      busyQ  <= busy;
    end
  end

  always_comb begin
    strb.toggleClr = busy & ~busyQ;
    strb.toggleAdv = busy & rdActQ & ~rdAct;
  end
endmodule

// File: rtl/wsp_datapath.sv
module wsp_datapath
  import wsp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  wspStrobe_t        strb,
  input  logic              rdAct,
  input  logic              busy,
  input  logic              opErase,
  input  logic [LANES-1:0]  lastMsb,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut,
  output logic              driveEn
);
  logic              toggleQ;
  logic [DATA_W-1:0] mixed;

  // Clear has priority over advance when both land on one edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               toggleQ <= 1'b0;
    else if (strb.toggleClr) toggleQ <= 1'b0;
    else if (strb.toggleAdv) toggleQ <= ~toggleQ;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int TOP = g * LANE_W + LANE_W - 1;
    localparam int BOT = g * LANE_W;
    assign mixed[TOP]   = busy ? (opErase ? 1'b0 : ~lastMsb[g]) : arrayData[TOP];
    assign mixed[TOP-1] = busy ? toggleQ : arrayData[TOP-1];
    assign mixed[TOP-2:BOT] = arrayData[TOP-2:BOT];
  end

  assign driveEn = rdAct;
  assign dataOut = rdAct ? mixed : '0;
endmodule

// File: rtl/wsp_top.sv
module wsp_top
  import wsp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSelN,
  input  logic              outEnN,
  input  logic              busy,
  input  logic              opErase,
  input  logic [LANES-1:0]  lastMsb,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut,
  output logic              driveEn
);
  wspStrobe_t strb;
  logic       rdAct;

  wsp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .outEnN(outEnN),
    .busy(busy), .rdAct(rdAct), .strb(strb)
  );

  wsp_datapath #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAct(rdAct), .busy(busy),
    .opErase(opErase), .lastMsb(lastMsb), .arrayData(arrayData),
    .dataOut(dataOut), .driveEn(driveEn)
  );
endmodule

// File: rtl/wsp_checker.sv
module wsp_checker #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              chipSelN,
  input logic              outEnN,
  input logic              busy,
  input logic              opErase,
  input logic [LANES-1:0]  lastMsb,
  input logic [DATA_W-1:0] arrayData,
  input logic [DATA_W-1:0] dataOut,
  input logic              driveEn
);
  localparam int HI = DATA_W - 1;
  localparam int LO = LANE_W - 1;

  a_r1_release: assert property (@(posedge clk) disable iff (!rstN)
    (chipSelN || outEnN) |-> (!driveEn && dataOut == '0));

  a_r2_passthru: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && !busy) |-> (dataOut == arrayData));

  a_r3_prog_poll: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && busy && !opErase) |->
      (dataOut[HI] != lastMsb[LANES-1] && dataOut[LO] != lastMsb[0]));

  a_r4_erase_poll: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && busy && opErase) |-> (!dataOut[HI] && !dataOut[LO]));

  a_r5_lanes_match: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && busy) |-> (dataOut[HI-1] == dataOut[LO-1]));

  a_r5_held_read: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && busy && $past(driveEn) && $past(busy)) |-> $stable(dataOut[LO-1]));

  a_r6_other_bits: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && busy) |-> (dataOut[LO-2:0] == arrayData[LO-2:0]));
endmodule

bind wsp_top wsp_checker #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .outEnN(outEnN),
  .busy(busy), .opErase(opErase), .lastMsb(lastMsb), .arrayData(arrayData),
  .dataOut(dataOut), .driveEn(driveEn)
);

// File: tb/wsp_top_tb.sv
module wsp_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chipSelN = 1'b1;
  logic        outEnN = 1'b1;
  logic        busy = 1'b0;
  logic        opErase = 1'b0;
  logic [1:0]  lastMsb = '0;
  logic [15:0] arrayData = '0;
  logic [15:0] dataOut;
  logic        driveEn;

  int nChk = 0;
  int nBad = 0;
  logic expTog = 1'b0;

  always #2.5 clk = ~clk;

  wsp_top u_dut (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .outEnN(outEnN),
    .busy(busy), .opErase(opErase), .lastMsb(lastMsb), .arrayData(arrayData),
    .dataOut(dataOut), .driveEn(driveEn)
  );

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expWord(input logic [15:0] arr);
    logic [15:0] w = arr;
    if (busy) begin
      w[15] = opErase ? 1'b0 : ~lastMsb[1];
      w[7]  = opErase ? 1'b0 : ~lastMsb[0];
      w[14] = expTog;
      w[6]  = expTog;
    end
    return w;
  endfunction

  // One read strobe held for 'hold' clocks, checked on every held cycle.
  task automatic doRead(input logic [15:0] arr, input int hold, input string req);
    @(negedge clk);
    arrayData = arr;
    chipSelN = 1'b0;
    outEnN = 1'b0;
    for (int h = 0; h < hold; h++) begin
      #1;
      check(req, {driveEn, dataOut}, {1'b1, expWord(arr)});
      @(negedge clk);
    end
    chipSelN = 1'b1;
    outEnN = 1'b1;
    if (busy) expTog = ~expTog;  // R5: one flip per completed strobe
    @(negedge clk);
  endtask

  task automatic startOp(input logic er, input logic [1:0] msb);
    @(negedge clk);
    busy = 1'b1;
    opErase = er;
    lastMsb = msb;
    expTog = 1'b0;  // R7
    @(negedge clk);
  endtask

  task automatic endOp();
    @(negedge clk);
    busy = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #100000;
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [15:0] pats [4];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3; pats[3] = 16'h3C5A;

    #1;
    check("R1 reset", {driveEn, dataOut}, 17'h0);
    check("R7 reset", {driveEn, dataOut}, 17'h0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2: idle reads pass array data straight through
    for (int p = 0; p < 4; p++) doRead(pats[p], 1, "R2 idle");

    // R1: only one of the two enables low
    @(negedge clk); arrayData = 16'hFFFF; chipSelN = 1'b1; outEnN = 1'b0; #1;
    check("R1 cs high", {driveEn, dataOut}, 17'h0);
    @(negedge clk); chipSelN = 1'b0; outEnN = 1'b1; #1;
    check("R1 oe high", {driveEn, dataOut}, 17'h0);
    @(negedge clk); chipSelN = 1'b1;

    // R3, R5, R6: program polling for every lane-MSB combination
    for (int m = 0; m < 4; m++) begin
      startOp(1'b0, m[1:0]);
      for (int p = 0; p < 4; p++) doRead(pats[p], 1 + (p % 3), "R3 R5 R6 program");
      // R1 while busy
      @(negedge clk); outEnN = 1'b0; #1;
      check("R1 busy released", {driveEn, dataOut}, 17'h0);
      @(negedge clk); outEnN = 1'b1;
      endOp();
      doRead(pats[m], 1, "R2 after program");
    end

    // R4: erase polling, odd number of reads so the toggle ends at 1
    startOp(1'b1, 2'b11);
    for (int r = 0; r < 5; r++) doRead(16'hFFFF, 1 + (r % 2), "R4 R5 erase");
    endOp();
    doRead(16'hFFFF, 2, "R2 erased");
    doRead(16'hFFFF, 1, "R2 no toggle idle");

    // R7: new operation after an odd read count starts with toggle 0
    startOp(1'b0, 2'b01);
    doRead(16'h1234, 1, "R7 first read");
    doRead(16'h1234, 3, "R5 held read");
    doRead(16'h1234, 1, "R5 after held");
    endOp();

    // R7: busy rises while a read is completing; clear wins
    startOp(1'b1, 2'b00);
    doRead(16'h0F0F, 1, "R7 erase first");
    @(negedge clk); busy = 1'b0;
    @(negedge clk); chipSelN = 1'b0; outEnN = 1'b0;
    @(negedge clk); chipSelN = 1'b1; outEnN = 1'b1; busy = 1'b1; expTog = 1'b0;
    @(negedge clk);
    doRead(16'h0F0F, 1, "R7 clear priority");
    endOp();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule